// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is the read side of a one-time-programmable bit memory that feeds a configuring device one bit per rising clock edge. An internal address counter walks through a bit image fixed at elaboration time. The image is produced by a generator function from a seed parameter, so no file or table is involved. A single control pin acts both as reset and as output enable, and a parameter sets its polarity. An active-low chip enable gates the device. The serial output is a data bit plus a drive-enable flag, so several devices can share one line.

Devices are chained by wiring each device's chip-enable output to the chip-enable input of the next. All devices share the clock, the data line and the reset/output-enable pin. Once a device has shifted out its last bit, it stops driving the line and pulls its chip-enable output low, which hands the line to the next device.

The control is a two-state machine. `ST_SHIFT` covers addresses zero to the terminal count (DEPTH-1). `ST_SPENT` covers the frozen state past the terminal count. There is one transition, `SHIFT->SPENT`, taken on an enabled clock edge while the address sits at the terminal count. Reset, from either state, returns the machine asynchronously to `ST_SHIFT` with address zero.

Top module: `cfgrom_serial`

## Requirements
- R1: The address advances on a rising clock edge only when chip enable is low and output enable is active. Otherwise it keeps its value, so after a pause the next bit shown is the one that was pending.
- R2: While reset is active, the address is held at zero, `data_oe` is 0, `data_out` is 0 and `ce_out_n` is 1. After release, the first bit shown is bit 0.
- R3: With `RST_ACT_HIGH`=1 (the default), `rst_oe`=1 means reset and 0 means output enabled. With `RST_ACT_HIGH`=0 the meaning is inverted.
- R4: With `ce_n`=1, `standby` is 1, `data_oe` is 0 and the address does not change, whatever the state of `rst_oe`. With `ce_n`=0, `standby` is 0.
- R5: In `ST_SHIFT` with the device enabled, `data_out` equals image bit A, where A is the current address. Bit i is the XOR-reduction of the 32-bit value (i*32'h9E3779B1 mod 2^32) XOR SEED. When `data_oe` is 0, `data_out` is 0.
- R6: The enabled clock edge taken at address DEPTH-1 enters `ST_SPENT`. From then on `data_oe` stays 0, the address stays frozen and `ce_out_n` goes low.
- R7: In `ST_SPENT`, `ce_out_n` equals `ce_n` while output enable is active, and is 1 while reset is active, until reset restarts the device.
- R8: In a chain of devices, at most one device drives the shared line in any cycle. The line carries the bits of the first image followed by the bits of the second.
- R9: Reset acts asynchronously: `data_oe` and `ce_out_n` take their reset values before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edges advance the address |
| rst_oe | input | 1 | Reset / output enable, polarity set by RST_ACT_HIGH |
| ce_n | input | 1 | Chip enable, active low |
| data_out | output | 1 | Serial data bit (0 when not driven) |
| data_oe | output | 1 | High when this device drives the shared line |
| ce_out_n | output | 1 | Chip enable for the next device in the chain, active low |
| standby | output | 1 | High while chip enable is inactive |

## Verification
A two-device chain is read end to end from reset with chip enable held low. This checks each image bit by bit, the handover at the terminal count, and that only one device drives the line. Directed pauses with chip enable high, made mid-image and after readout, separate a counter that holds its value from one that skips bits, and show whether the chip-enable output follows its input. Random stimulus mixes chip-enable pauses with occasional resets at arbitrary addresses, which exposes any reset that is synchronous or leaves the address non-zero. A third device, built with the inverted reset polarity, gets its own chip-enable pattern; it fails at once if the polarity parameter is ignored.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

    typedef enum logic {
        ST_SHIFT = 1'b0,
        ST_SPENT = 1'b1
    } seq_e;

    localparam logic [31:0] HASH_MULT = 32'h9E37_79B1;

    function automatic logic image_bit(input logic [31:0] seed, input int unsigned idx);
        logic [31:0] h;
        h = (32'(idx) * HASH_MULT) ^ seed;
        return ^h;
    endfunction

endpackage

// File: rtl/cfgrom_addr_ctr.sv
module cfgrom_addr_ctr #(
    parameter int DEPTH = 48,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_act,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign at_last = (addr == LAST);

    always_ff @(posedge clk or posedge rst_act) begin
        if (rst_act)
            addr <= '0;
        else if (step && !at_last)
            addr <= addr + 1'b1;
    end
endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
    import cfgrom_pkg::*;
(
    input  logic clk,
    input  logic rst_act,
    input  logic oe_act,
    input  logic ce_n,
    input  logic at_last,
    output logic step,
    output logic in_past
);
    seq_e state, state_nx;

    always_ff @(posedge clk or posedge rst_act) begin
        if (rst_act)
            state <= ST_SHIFT;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SHIFT: if (oe_act && !ce_n && at_last) state_nx = ST_SPENT;
            ST_SPENT: state_nx = ST_SPENT;
            default:  state_nx = ST_SHIFT;
        endcase
    end

    always_comb begin
        step    = 1'b0;
        in_past = 1'b0;
        unique case (state)
            ST_SHIFT: step    = oe_act && !ce_n;
            ST_SPENT: in_past = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgrom_out.sv
module cfgrom_out
    import cfgrom_pkg::*;
#(
    parameter int          DEPTH = 48,
    parameter int          AW    = $clog2(DEPTH),
    parameter logic [31:0] SEED  = 32'h1234_5678
) (
    input  logic [AW-1:0] addr,
    input  logic          in_past,
    input  logic          oe_act,
    input  logic          ce_n,
    output logic          data_out,
    output logic          data_oe,
    output logic          ce_out_n,
    output logic          standby
);
    function automatic logic [DEPTH-1:0] build_image();
        logic [DEPTH-1:0] img;
        for (int i = 0; i < DEPTH; i++)
            img[i] = image_bit(SEED, i);
        return img;
    endfunction

    localparam logic [DEPTH-1:0] IMAGE = build_image();

    logic sel;
    logic bit_at;

    assign sel      = oe_act && !ce_n;
    assign bit_at   = IMAGE[addr];
    assign data_oe  = sel && !in_past;
    assign data_out = data_oe && bit_at;
    assign ce_out_n = !(sel && in_past);
    assign standby  = ce_n;
endmodule

// File: rtl/cfgrom_serial.sv
module cfgrom_serial #(
    parameter int          DEPTH        = 48,
    parameter logic [31:0] SEED         = 32'h1234_5678,
    parameter bit          RST_ACT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_oe,
    input  logic ce_n,
    output logic data_out,
    output logic data_oe,
    output logic ce_out_n,
    output logic standby
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    logic          rst_act;
    logic          oe_act;
    logic          step;
    logic          at_last;
    logic          in_past;
    logic [AW-1:0] addr;

    generate
        if (RST_ACT_HIGH) begin : g_rst_hi
            assign rst_act = rst_oe;
        end else begin : g_rst_lo
            assign rst_act = ~rst_oe;
        end
    endgenerate

    assign oe_act = ~rst_act;

    cfgrom_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
        .clk(clk), .rst_act(rst_act), .step(step),
        .addr(addr), .at_last(at_last)
    );

    cfgrom_seq u_seq (
        .clk(clk), .rst_act(rst_act), .oe_act(oe_act), .ce_n(ce_n),
        .at_last(at_last), .step(step), .in_past(in_past)
    );

    cfgrom_out #(.DEPTH(DEPTH), .AW(AW), .SEED(SEED)) u_out (
        .addr(addr), .in_past(in_past), .oe_act(oe_act), .ce_n(ce_n),
        .data_out(data_out), .data_oe(data_oe),
        .ce_out_n(ce_out_n), .standby(standby)
    );
endmodule

// File: rtl/cfgrom_serial_chk.sv
module cfgrom_serial_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_act,
    input logic          ce_n,
    input logic          data_oe,
    input logic          ce_out_n,
    input logic          standby,
    input logic          in_past,
    input logic [AW-1:0] addr
);
    always @(negedge clk) begin
        if (rst_act === 1'b1)
            AST_RESET_QUIET: assert (!data_oe && ce_out_n); // R2
    end

    AST_STANDBY_TRISTATE: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |-> (!data_oe && standby)); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |=> $stable(addr)); // R1

    AST_FREEZE_PAST: assert property (@(posedge clk) disable iff (rst_act)
        in_past |=> (in_past && $stable(addr))); // R6

    AST_FOLLOW_CE: assert property (@(posedge clk) disable iff (rst_act)
        in_past |-> (ce_out_n == ce_n)); // R7

    AST_SINGLE_ROLE: assert property (@(posedge clk) disable iff (rst_act)
        !(data_oe && !ce_out_n)); // R8
endmodule

bind cfgrom_serial cfgrom_serial_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_act(rst_act), .ce_n(ce_n), .data_oe(data_oe),
    .ce_out_n(ce_out_n), .standby(standby), .in_past(in_past), .addr(addr)
);

// File: tb/sim_cfgrom_serial.sv
`timescale 1ns/1ps
module sim_cfgrom_serial;
    localparam int          D0 = 48, D1 = 40, D2 = 24;
    localparam logic [31:0] S0 = 32'h1234_5678, S1 = 32'hCAFE_0001, S2 = 32'h5A5A_0F0F;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, ce0_n = 1'b1, ce2_n = 1'b1;
    logic d0, oe0, co0, sb0, d1, oe1, co1, sb1, d2, oe2, co2, sb2;

    cfgrom_serial #(.DEPTH(D0), .SEED(S0)) u0 (
        .clk(clk), .rst_oe(rst), .ce_n(ce0_n),
        .data_out(d0), .data_oe(oe0), .ce_out_n(co0), .standby(sb0));
    cfgrom_serial #(.DEPTH(D1), .SEED(S1)) u1 (
        .clk(clk), .rst_oe(rst), .ce_n(co0),
        .data_out(d1), .data_oe(oe1), .ce_out_n(co1), .standby(sb1));
    cfgrom_serial #(.DEPTH(D2), .SEED(S2), .RST_ACT_HIGH(1'b0)) u2 (
        .clk(clk), .rst_oe(~rst), .ce_n(ce2_n),
        .data_out(d2), .data_oe(oe2), .ce_out_n(co2), .standby(sb2));

    int n_chk = 0, n_bad = 0;
    int m_addr [3] = '{0, 0, 0};
    bit m_past [3] = '{0, 0, 0};
    int dep    [3] = '{D0, D1, D2};
    logic [31:0] sd [3] = '{S0, S1, S2};

    function automatic logic ref_bit(input logic [31:0] seed, input int idx);
        logic [31:0] h;
        h = idx * 32'd2654435761;
        h = h ^ seed;
        return ^h;
    endfunction

    // expected per-device outputs from the model state and present inputs
    function automatic logic e_oe(input int k, input logic ce);
        return !rst && !ce && !m_past[k];
    endfunction
    function automatic logic e_co(input int k, input logic ce);
        return !(!rst && !ce && m_past[k]);
    endfunction
    function automatic logic e_d(input int k, input logic ce);
        return e_oe(k, ce) && ref_bit(sd[k], m_addr[k]);
    endfunction

    always @(posedge clk) begin
        logic c [3];
        c[0] = ce0_n; c[1] = e_co(0, ce0_n); c[2] = ce2_n;
        for (int k = 0; k < 3; k++) begin
            if (rst) begin
                m_addr[k] = 0; m_past[k] = 0;
            end else if (!c[k] && !m_past[k]) begin
                if (m_addr[k] == dep[k] - 1) m_past[k] = 1;
                else m_addr[k] = m_addr[k] + 1;
            end
        end
    end

    task automatic cmp(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string dtag);
        logic c1;
        c1 = e_co(0, ce0_n);
        cmp(rst ? "R9 oe0" : dtag, oe0, e_oe(0, ce0_n));
        cmp(rst ? "R2 d0" : "R5 d0", d0, e_d(0, ce0_n));
        cmp(rst ? "R2 co0" : "R7 co0", co0, c1);
        cmp("R4 sb0", sb0, ce0_n);
        cmp("R6 oe1", oe1, e_oe(1, c1));
        cmp("R5 d1", d1, e_d(1, c1));
        cmp("R7 co1", co1, e_co(1, c1));
        cmp("R3 oe2", oe2, e_oe(2, ce2_n));
        cmp("R3 d2", d2, e_d(2, ce2_n));
        cmp("R3 co2", co2, e_co(2, ce2_n));
        n_chk++;
        if (oe0 && oe1) begin
            n_bad++;
            $display("FAIL R8: two drivers oe0=%b oe1=%b expected one", oe0, oe1);
        end
        cmp("R8 bus", (oe0 & d0) | (oe1 & d1), e_d(0, ce0_n) | e_d(1, c1));
    endtask

    task automatic cyc(input logic r, input logic c0, input logic c2, input string dtag);
        @(negedge clk);
        rst = r; ce0_n = c0; ce2_n = c2;
        #1;
        check_all(dtag);
    endtask

    bit finished = 0;

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R2: reset state
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R2 oe0");
        // R1 R4: chip enable high, counter must stay at zero
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, "R4 oe0");
        // R5 R6 R8: full chain readout
        for (int i = 0; i < D0 + D1 + 4; i++) cyc(0, 0, 0, "R6 oe0");
        // R7: chip-enable output follows input after readout
        for (int i = 0; i < 6; i++) cyc(0, i % 2, i % 3 == 0, "R7 oe0");
        // R9 R2: asynchronous reset then restart from bit 0
        cyc(1, 0, 0, "R9 oe0");
        cyc(0, 0, 0, "R2 oe0");
        // R1: mid-image pause
        for (int i = 0; i < 7; i++) cyc(0, 0, 0, "R5 oe0");
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, "R1 oe0");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R1 oe0");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic r, a, b;
            r = ($urandom_range(299) == 0);
            a = ($urandom_range(7) == 0);
            b = ($urandom_range(7) == 0);
            cyc(r, a, b, "R1 oe0");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule